// File: doc/BRIEF.md
# Indexed Codec Control Register File

This block is the byte-wide control front end of an audio codec. A host reaches it through four direct ports, selected by a 2-bit address. The first port holds an index pointer. The second reads and writes the indirect configuration register that the pointer selects. The third reports and acknowledges the interrupt. The fourth is a programmed-I/O data slot that is not backed by storage. Behind the data port sits a file of up to 32 indirect configuration registers. Each register comes out of reset with its own value and obeys its own write rule.

Mode logic is part of the block. A mode bit in the identity register widens the indirect index from 4 to 5 bits. Sample-format writes take effect only while a mode-change enable is open. A short calibration-busy indication is reported when that enable opens. The interrupt flag is set by a strobe from the playback counter and cleared by the host through two acknowledge paths. The interrupt request output follows that flag.

Top module: `codec_ctl_regs`

## Requirements
- R1: Port 0 stores bits 6:0 of the written byte. A read of port 0 returns that value with bit 7 always 0. After reset it reads 0x40, so the mode-change enable (bit 6) is set.
- R2: The data port (port 1) selects indirect register `index[3:0]` while bit 6 of register 12 is 0, and `index[4:0]` while that bit is 1.
- R3: After reset, registers 2, 3, 4, 5, 18 and 19 read 0x88, registers 6 and 7 read 0x80, register 9 reads 0x08, register 12 reads 0x8A, and registers 25 and 26 read 0xA0. Every other indirect register reads 0x00.
- R4: Writes to registers 22, 27 and 29 have no effect; these registers read 0x00.
- R5: Register 11 ignores writes. A write to register 12 changes only its bit 6.
- R6: A write to register 8 stores the full byte when index bit 6 is set. When index bit 6 is clear but register 24 bit 4 is set, only bits 7:4 are stored and bits 3:0 are kept. Otherwise the write is dropped.
- R7: A write to register 9 stores bit 5 as 0 and all other bits as written.
- R8: A port-0 write that changes index bit 6 from 0 to 1, while register 9 bits 4:3 are non-zero, loads a calibration count of 1. Each read of register 11 with a non-zero count returns bit 5 set and decrements the count. Otherwise bit 5 of that read shows the stored value.
- R9: Any write to port 2 clears the interrupt flag and clears bits 6:4 of register 24.
- R10: A write to register 24 with bit 4 clear, while that bit was set, clears the interrupt flag.
- R11: A pulse on the interrupt-set strobe sets the interrupt flag and register 24 bit 4. The set wins over a clear in the same cycle. A read of port 2 returns the flag in bit 0 with the other bits 0, and the interrupt output equals the flag.
- R12: Port 3 reads 0x00. A write to port 3 changes no register and does not change the interrupt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Direct port select (0 index, 1 data, 2 status, 3 PIO) |
| busRd | input | 1 | Read strobe, one cycle per access |
| busWr | input | 1 | Write strobe, one cycle per access |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Combinational read data for the addressed port |
| irqSetStb | input | 1 | Interrupt-set pulse from the playback counter |
| irqOut | output | 1 | Interrupt request, equal to the status flag |

## Verification
The properties assume that the host never raises the read and write strobes in the same cycle. They also assume that the address is valid whenever a strobe is high. The interrupt-set strobe is treated as free-running and may coincide with any bus access. The stimulus issues one access per strobe cycle and returns both strobes to idle between accesses. It raises the set strobe alone, except in one deliberate case that puts it in the same cycle as a status-port write.

// File: rtl/codec_ctl_pkg.sv
package codec_ctl_pkg;

  // Direct port addresses
  localparam logic [1:0] PORT_IDX  = 2'd0;
  localparam logic [1:0] PORT_DATA = 2'd1;
  localparam logic [1:0] PORT_STAT = 2'd2;
  localparam logic [1:0] PORT_PIO  = 2'd3;

  // Indirect register numbers whose rules differ
  localparam int IDX_FMT     = 8;
  localparam int IDX_CFG     = 9;
  localparam int IDX_ERRINIT = 11;
  localparam int IDX_MODE    = 12;
  localparam int IDX_RSV_A   = 22;
  localparam int IDX_ALTSTAT = 24;
  localparam int IDX_RSV_B   = 27;
  localparam int IDX_RSV_C   = 29;

  // Bit positions
  localparam int MCE_BIT     = 6;
  localparam int MODE2_BIT   = 6;
  localparam int PBK_BIT     = 4;
  localparam int TMR_BIT     = 6;
  localparam int CAL_BIT     = 5;
  localparam int CFG_ZERO    = 5;

  typedef enum logic [2:0] {
    WK_NONE,
    WK_PLAIN,
    WK_MODE,
    WK_FMT_FULL,
    WK_FMT_HI,
    WK_CFG,
    WK_ALTSTAT
  } wrKindE;

  typedef struct packed {
    logic   idxWr;
    logic   dataWr;
    logic   statWr;
    logic   dataRd;
    wrKindE kind;
  } ctlStrobeS;

  function automatic logic [7:0] regResetValue(input int n);
    case (n)
      2, 3, 4, 5, 18, 19: regResetValue = 8'h88;
      6, 7:               regResetValue = 8'h80;
      9:                  regResetValue = 8'h08;
      12:                 regResetValue = 8'h8A;
      25, 26:             regResetValue = 8'hA0;
      default:            regResetValue = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/codec_ctl_ctrl.sv
module codec_ctl_ctrl
  import codec_ctl_pkg::*;
#(
  parameter int NUM_IREGS = 32,
  localparam int IDX_W = $clog2(NUM_IREGS)
) (
  input  logic [1:0]       busAddr,
  input  logic             busRd,
  input  logic             busWr,
  input  logic [IDX_W-1:0] iIndex,
  input  logic             mceOn,
  input  logic             pmceOn,
  output ctlStrobeS        stb
);

  wrKindE kindSel;

  always_comb begin
    case (int'(iIndex))
      IDX_RSV_A, IDX_RSV_B, IDX_RSV_C, IDX_ERRINIT: kindSel = WK_NONE;
      IDX_MODE:    kindSel = WK_MODE;
      IDX_CFG:     kindSel = WK_CFG;
      IDX_ALTSTAT: kindSel = WK_ALTSTAT;
      IDX_FMT: begin
        if (mceOn)       kindSel = WK_FMT_FULL;
        else if (pmceOn) kindSel = WK_FMT_HI;
        else             kindSel = WK_NONE;
      end
      default:     kindSel = WK_PLAIN;
    endcase
  end

  always_comb begin
    stb.idxWr  = busWr && (busAddr == PORT_IDX);
    stb.dataWr = busWr && (busAddr == PORT_DATA);
    stb.statWr = busWr && (busAddr == PORT_STAT);
    stb.dataRd = busRd && (busAddr == PORT_DATA);
    stb.kind   = kindSel;
  end

endmodule

// File: rtl/codec_ctl_datapath.sv
module codec_ctl_datapath
  import codec_ctl_pkg::*;
#(
  parameter int NUM_IREGS = 32,
  parameter int DATA_W    = 8,
  parameter int CAL_INIT  = 1,
  parameter int CAL_W     = 2,
  localparam int IDX_W = $clog2(NUM_IREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobeS         stb,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              irqSetStb,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut,
  output logic [IDX_W-1:0]  iIndex,
  output logic              mceOn,
  output logic              pmceOn
);

  logic [DATA_W-2:0] idxReg;
  logic              intFlag;
  logic [CAL_W-1:0]  calCnt;
  logic [DATA_W-1:0] iregs   [NUM_IREGS];
  logic [DATA_W-1:0] regNxt  [NUM_IREGS];
  logic              mode2;
  logic              calHit;
  logic              pbkDrop;

  assign mode2  = iregs[IDX_MODE][MODE2_BIT];
  assign iIndex = mode2 ? idxReg[IDX_W-1:0] : IDX_W'(idxReg[3:0]);
  assign mceOn  = idxReg[MCE_BIT];
  assign pmceOn = iregs[IDX_ALTSTAT][PBK_BIT];
  assign irqOut = intFlag;

  assign calHit  = (int'(iIndex) == IDX_ERRINIT) && (calCnt != '0);
  assign pbkDrop = stb.dataWr && (stb.kind == WK_ALTSTAT)
                   && iregs[IDX_ALTSTAT][PBK_BIT] && !busWdata[PBK_BIT];

  // Next state of the indirect file
  always_comb begin
    for (int i = 0; i < NUM_IREGS; i++) begin
      regNxt[i] = iregs[i];
      if (stb.dataWr && int'(iIndex) == i) begin
        case (stb.kind)
          WK_PLAIN, WK_ALTSTAT, WK_FMT_FULL: regNxt[i] = busWdata;
          WK_MODE:   regNxt[i][MODE2_BIT] = busWdata[MODE2_BIT];
          WK_FMT_HI: regNxt[i] = {busWdata[DATA_W-1:4], iregs[i][3:0]};
          WK_CFG: begin
            regNxt[i] = busWdata;
            regNxt[i][CFG_ZERO] = 1'b0;
          end
          default: regNxt[i] = iregs[i];
        endcase
      end
    end
    if (stb.statWr) regNxt[IDX_ALTSTAT][TMR_BIT:PBK_BIT] = '0;
    if (irqSetStb)  regNxt[IDX_ALTSTAT][PBK_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_IREGS; i++) iregs[i] <= DATA_W'(regResetValue(i));
    end else begin
      for (int i = 0; i < NUM_IREGS; i++) iregs[i] <= regNxt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idxReg <= (DATA_W-1)'(8'h40);
    end else if (stb.idxWr) begin
      idxReg <= busWdata[DATA_W-2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      intFlag <= 1'b0;
    end else if (irqSetStb) begin
      intFlag <= 1'b1;
    end else if (stb.statWr || pbkDrop) begin
      intFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      calCnt <= '0;
    end else if (stb.idxWr && !idxReg[MCE_BIT] && busWdata[MCE_BIT]
                 && (iregs[IDX_CFG][4:3] != 2'b00)) begin
      calCnt <= CAL_W'(CAL_INIT);
    end else if (stb.dataRd && calHit) begin
      calCnt <= calCnt - 1'b1;
    end
  end

  always_comb begin
    case (busAddr)
      PORT_IDX:  busRdata = {1'b0, idxReg};
      PORT_DATA: begin
        busRdata = iregs[iIndex];
        if (calHit) busRdata[CAL_BIT] = 1'b1;
      end
      PORT_STAT: busRdata = {{(DATA_W-1){1'b0}}, intFlag};
      default:   busRdata = '0;
    endcase
  end

endmodule

// File: rtl/codec_ctl_regs.sv
module codec_ctl_regs
  import codec_ctl_pkg::*;
#(
  parameter int NUM_IREGS = 32,
  parameter int DATA_W    = 8,
  parameter int CAL_INIT  = 1,
  parameter int CAL_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              irqSetStb,
  output logic              irqOut
);

  localparam int IDX_W = $clog2(NUM_IREGS);

  ctlStrobeS        stb;
  logic [IDX_W-1:0] iIndex;
  logic             mceOn;
  logic             pmceOn;

  codec_ctl_ctrl #(.NUM_IREGS(NUM_IREGS)) u_ctrl (
    .busAddr (busAddr),
    .busRd   (busRd),
    .busWr   (busWr),
    .iIndex  (iIndex),
    .mceOn   (mceOn),
    .pmceOn  (pmceOn),
    .stb     (stb)
  );

  codec_ctl_datapath #(
    .NUM_IREGS (NUM_IREGS),
    .DATA_W    (DATA_W),
    .CAL_INIT  (CAL_INIT),
    .CAL_W     (CAL_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .irqSetStb (irqSetStb),
    .busRdata  (busRdata),
    .irqOut    (irqOut),
    .iIndex    (iIndex),
    .mceOn     (mceOn),
    .pmceOn    (pmceOn)
  );

endmodule

// File: rtl/codec_ctl_regs_chk.sv
module codec_ctl_regs_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        busAddr,
  input logic              busRd,
  input logic              busWr,
  input logic [DATA_W-1:0] busRdata,
  input logic              irqSetStb,
  input logic              irqOut
);

  a_r1_index_msb_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (busAddr == 2'd0) |-> !busRdata[DATA_W-1]);

  a_r11_status_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    (busAddr == 2'd2) |-> (busRdata == {{(DATA_W-1){1'b0}}, irqOut}));

  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    irqSetStb |=> irqOut);

  a_r9_status_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (busWr && busAddr == 2'd2 && !irqSetStb) |=> !irqOut);

  a_r12_pio_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (busAddr == 2'd3) |-> (busRdata == '0));

  a_r12_pio_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (busWr && busAddr == 2'd3 && !irqSetStb) |=> (irqOut == $past(irqOut)));

  a_bus_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busRd && busWr));

endmodule

bind codec_ctl_regs codec_ctl_regs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busAddr   (busAddr),
  .busRd     (busRd),
  .busWr     (busWr),
  .busRdata  (busRdata),
  .irqSetStb (irqSetStb),
  .irqOut    (irqOut)
);

// File: tb/test_codec_ctl_regs.sv
module test_codec_ctl_regs;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic       busRd = 1'b0;
  logic       busWr = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic       irqSetStb = 1'b0;
  logic       irqOut;

  int nChecks = 0;
  int nErrors = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } expItemT;

  expItemT sbq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  codec_ctl_regs i_codec_ctl_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .busAddr   (busAddr),
    .busRd     (busRd),
    .busWr     (busWr),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .irqSetStb (irqSetStb),
    .irqOut    (irqOut)
  );

  // Monitor: compare read data against the scoreboard queue
  always @(negedge clk) begin
    if (busRd) begin
      if (sbq.size() == 0) begin
        nChecks++;
        nErrors++;
        $display("FAIL scoreboard: read with no expected item, got %h expected none", busRdata);
      end else begin
        expItemT it;
        it = sbq.pop_front();
        nChecks++;
        if (busRdata !== it.exp) begin
          nErrors++;
          $display("FAIL %s: read data %h expected %h", it.tag, busRdata, it.exp);
        end
      end
    end
  end

  function automatic logic [7:0] expReset(input int n);
    case (n)
      2, 3, 4, 5, 18, 19: expReset = 8'h88;
      6, 7:               expReset = 8'h80;
      9:                  expReset = 8'h08;
      12:                 expReset = 8'h8A;
      25, 26:             expReset = 8'hA0;
      default:            expReset = 8'h00;
    endcase
  endfunction

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(posedge clk); #1;
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(posedge clk); #1;
    sbq.push_back('{exp, tag});
    busAddr = a; busRd = 1'b1;
    @(posedge clk); #1;
    busRd = 1'b0;
  endtask

  task automatic setIdx(input logic [4:0] idx, input logic mce);
    busWrite(2'd0, {1'b0, mce, 1'b0, idx});
  endtask

  task automatic wrInd(input logic [4:0] idx, input logic mce, input logic [7:0] val);
    setIdx(idx, mce);
    busWrite(2'd1, val);
  endtask

  task automatic rdInd(input logic [4:0] idx, input logic mce, input logic [7:0] exp,
                       input string tag);
    setIdx(idx, mce);
    busRead(2'd1, exp, tag);
  endtask

  task automatic pulseSet();
    @(posedge clk); #1;
    irqSetStb = 1'b1;
    @(posedge clk); #1;
    irqSetStb = 1'b0;
  endtask

  task automatic chkIrq(input logic exp, input string tag);
    nChecks++;
    if (irqOut !== exp) begin
      nErrors++;
      $display("FAIL %s: irqOut %b expected %b", tag, irqOut, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog: run still active, got timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 / R11 / R12 reset state of the direct ports
    chkIrq(1'b0, "R11 reset");
    busRead(2'd0, 8'h40, "R1 reset index");
    busRead(2'd2, 8'h00, "R11 reset status");
    busRead(2'd3, 8'h00, "R12 pio read");

    // R3 reset values, low half with 4-bit indexing
    for (int i = 0; i < 16; i++) rdInd(5'(i), 1'b1, expReset(i), "R3 low");

    // R2 / R5 enable the wide index
    wrInd(5'd12, 1'b1, 8'h40);
    rdInd(5'd12, 1'b1, 8'hCA, "R5 mode bit");
    for (int i = 16; i < 32; i++) rdInd(5'(i), 1'b1, expReset(i), "R3 high");

    // R2 narrowing aliases index 20 onto register 4
    wrInd(5'd20, 1'b1, 8'h5A);
    rdInd(5'd20, 1'b1, 8'h5A, "R2 wide write");
    wrInd(5'd12, 1'b1, 8'h00);
    busWrite(2'd0, 8'h54);
    busRead(2'd1, 8'h88, "R2 narrow alias");
    wrInd(5'd12, 1'b1, 8'h40);
    rdInd(5'd20, 1'b1, 8'h5A, "R2 wide again");

    // R5 only bit 6 of register 12; register 11 read-only
    wrInd(5'd12, 1'b1, 8'hFF);
    rdInd(5'd12, 1'b1, 8'hCA, "R5 mode mask");
    wrInd(5'd11, 1'b1, 8'hFF);
    rdInd(5'd11, 1'b1, 8'h00, "R5 read-only");

    // R4 reserved slots
    wrInd(5'd22, 1'b1, 8'hFF);
    rdInd(5'd22, 1'b1, 8'h00, "R4 reg22");
    wrInd(5'd27, 1'b1, 8'hFF);
    rdInd(5'd27, 1'b1, 8'h00, "R4 reg27");
    wrInd(5'd29, 1'b1, 8'hFF);
    rdInd(5'd29, 1'b1, 8'h00, "R4 reg29");

    // R7 bit 5 of register 9 stays zero
    wrInd(5'd9, 1'b1, 8'hFF);
    rdInd(5'd9, 1'b1, 8'hDF, "R7 cfg mask");

    // R6 format register gating
    wrInd(5'd8, 1'b1, 8'h5C);
    rdInd(5'd8, 1'b0, 8'h5C, "R6 full write");
    busWrite(2'd1, 8'hA3);
    busRead(2'd1, 8'h5C, "R6 dropped");
    wrInd(5'd24, 1'b0, 8'h10);
    wrInd(5'd8, 1'b0, 8'hA3);
    rdInd(5'd8, 1'b0, 8'hAC, "R6 upper nibble");
    wrInd(5'd24, 1'b0, 8'h00);
    chkIrq(1'b0, "R10 no set");

    // R8 calibration indication
    busWrite(2'd0, 8'h4B);
    busRead(2'd1, 8'h20, "R8 busy first read");
    busRead(2'd1, 8'h00, "R8 busy cleared");
    wrInd(5'd9, 1'b1, 8'h00);
    rdInd(5'd9, 1'b1, 8'h00, "R7 cfg zero");
    setIdx(5'd11, 1'b0);
    setIdx(5'd11, 1'b1);
    busRead(2'd1, 8'h00, "R8 no load when cfg idle");

    // R11 set strobe, R9 status acknowledge
    pulseSet();
    chkIrq(1'b1, "R11 set");
    busRead(2'd2, 8'h01, "R11 status bit");
    rdInd(5'd24, 1'b1, 8'h10, "R11 altstat bit4");
    busWrite(2'd1, 8'h70);
    chkIrq(1'b1, "R10 bit4 kept");
    busWrite(2'd2, 8'h00);
    chkIrq(1'b0, "R9 ack");
    busRead(2'd1, 8'h00, "R9 altstat cleared");

    // R10 clear by register 24 write
    pulseSet();
    chkIrq(1'b1, "R11 set again");
    wrInd(5'd24, 1'b1, 8'h00);
    chkIrq(1'b0, "R10 altstat ack");
    busRead(2'd2, 8'h00, "R10 status clear");

    // R11 set wins over simultaneous acknowledge
    @(posedge clk); #1;
    busAddr = 2'd2; busWdata = 8'h00; busWr = 1'b1; irqSetStb = 1'b1;
    @(posedge clk); #1;
    busWr = 1'b0; irqSetStb = 1'b0;
    chkIrq(1'b1, "R11 set wins");
    rdInd(5'd24, 1'b1, 8'h10, "R11 set wins altstat");

    // R12 port 3 writes are inert
    busWrite(2'd3, 8'hFF);
    chkIrq(1'b1, "R12 pio write");
    busRead(2'd3, 8'h00, "R12 pio read after write");
    busRead(2'd0, 8'h58, "R12 index untouched");

    // R1 bit 7 never stored
    busWrite(2'd0, 8'hFF);
    busRead(2'd0, 8'h7F, "R1 msb dropped");

    repeat (2) @(posedge clk);
    if (sbq.size() != 0) begin
      nChecks++;
      nErrors++;
      $display("FAIL scoreboard: %0d items left, expected 0", sbq.size());
    end
    finishRun();
  end

endmodule